// File: doc/BRIEF.md
# Register Write-Protect Controller with Timed Relock

This block sits in front of the configuration registers and the small retained RAM of a real-time-clock peripheral and decides, write by write, whether a bus write may reach them. After power-on reset the bank is open, so software can load the time, control bits, alarms and retained settings. The bank then closes. Software can close it with a lock command. If software has not done so within a fixed number of seconds, the block closes it on its own. The same deadline forces the tamper-detection enables on if software left them off.

Once the bank is closed, only a two-write key sequence reopens it. Every service operation, such as clearing an interrupt, updating retained data or changing control bits, starts with this sequence. The window it opens lasts two seconds. It closes earlier if software issues the lock command.

Time is counted on a once-per-second tick input. The write port is a plain single-cycle strobe. The block decides on each write in the same cycle and never stalls the bus, so it has no back-pressure. Key and lock writes are consumed by the block and are never passed to the bank.

Top module: `wp_guard`

## Requirements
- R1: After power-on reset, `locked` is 0 and `tamper_force` is 0, so the bank accepts writes.
- R2: `wr_en_gate` is 1 in the same cycle as a write strobe exactly when `locked` is 0 and the address is neither the key address (0xF) nor the lock address (0xE).
- R3: A write to the lock address with data bit 0 set, made while `locked` is 0, makes `locked` 1 from the next cycle. A lock write with bit 0 clear has no effect.
- R4: If the bank is still in its post-reset open state when the 15th tick after reset arrives, `locked` becomes 1 in the following cycle.
- R5: On the 15th tick after reset, `tamper_force` becomes 1 in the following cycle if `tamper_sw_en` is 0 in that cycle. It then stays 1 until reset. If `tamper_sw_en` is 1 in that cycle, `tamper_force` stays 0.
- R6: While `locked` is 1, no write of any address produces `wr_en_gate`.
- R7: While locked, a write of 0x55 to the key address followed by a write of 0xAA to the key address makes `locked` 0 in the cycle after the 0xAA write. The two writes must be consecutive strobed writes; idle cycles between them are allowed.
- R8: A strobed write to any other address between the two key writes, or a key write of any value other than 0x55 or 0xAA, leaves the bank locked. The sequence then has to start again with 0x55.
- R9: After an unlock, the bank locks again in the cycle after the second tick that arrives after the unlock. A tick in the same cycle as the 0xAA write does not count.
- R10: A lock command during an unlock window cancels the pending relock count, so the next unlock again gets two full ticks.
- R11: Key-address writes made while unlocked pass no write and do not change `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_stb | input | 1 | Bus write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| tamper_sw_en | input | 1 | Tamper-enable bits as currently set by software |
| wr_en_gate | output | 1 | Write is allowed to reach the bank |
| locked | output | 1 | Writes are blocked |
| tamper_force | output | 1 | Tamper enables forced on |

## Verification
The hardest situations to reach are the interactions between the two timeouts and the key sequence. Examples are a tick landing in the very cycle the 0xAA write completes an unlock, and the power-on deadline expiring while a service window is already open. The stimulus reaches them by driving ticks directly, interleaved with key writes at chosen cycles. After a second reset it locks early, unlocks, and lets the 15th tick fall inside the open window. A behavioural model tracks the expected outputs and compares them on every clock.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    WP_BOOT = 2'd0,
    WP_SHUT = 2'd1,
    WP_OPEN = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wp_sec_timer.sv
module wp_sec_timer #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic fire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // fire on the tick that completes LIMIT counted ticks
  assign fire = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (run && tick)  cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq #(
  parameter int unsigned   DW    = 8,
  parameter logic [DW-1:0] KEY_A = 8'h55,
  parameter logic [DW-1:0] KEY_B = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          stb,
  input  logic          is_key,
  input  logic [DW-1:0] data,
  output logic          unlock
);
  logic half;

  assign unlock = armed && stb && is_key && (data == KEY_B) && half;

  // any strobed write re-evaluates the first half; idle cycles hold it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half <= 1'b0;
    else if (!armed) half <= 1'b0;
    else if (stb)    half <= is_key && (data == KEY_A);
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int unsigned   AW          = 4,
  parameter int unsigned   DW          = 8,
  parameter logic [AW-1:0] KEY_ADDR    = 4'hF,
  parameter logic [AW-1:0] LOCK_ADDR   = 4'hE,
  parameter logic [DW-1:0] KEY_A       = 8'h55,
  parameter logic [DW-1:0] KEY_B       = 8'hAA,
  parameter int unsigned   BOOT_SECS   = 15,
  parameter int unsigned   RELOCK_SECS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tamper_sw_en,
  output logic          wr_en_gate,
  output logic          locked,
  output logic          tamper_force
);
  wp_state_e st, st_nx;
  logic boot_done;
  logic is_key, is_lock, lock_cmd, unlock, boot_fire, win_fire;

  assign is_key     = (wr_addr == KEY_ADDR);
  assign is_lock    = (wr_addr == LOCK_ADDR);
  assign locked     = (st == WP_SHUT);
  assign lock_cmd   = wr_stb && is_lock && wr_data[0] && !locked;
  assign wr_en_gate = wr_stb && !locked && !is_key && !is_lock;

  wp_key_seq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .armed(locked), .stb(wr_stb),
    .is_key(is_key), .data(wr_data), .unlock(unlock)
  );

  wp_sec_timer #(.LIMIT(BOOT_SECS)) u_boot (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .run(!boot_done),
    .tick(sec_tick), .fire(boot_fire)
  );

  wp_sec_timer #(.LIMIT(RELOCK_SECS)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(unlock || lock_cmd), .run(st == WP_OPEN),
    .tick(sec_tick), .fire(win_fire)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      WP_BOOT: if (lock_cmd || boot_fire) st_nx = WP_SHUT;
      WP_SHUT: if (unlock)                st_nx = WP_OPEN;
      WP_OPEN: if (lock_cmd || win_fire)  st_nx = WP_SHUT;
      default:                            st_nx = WP_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= WP_BOOT;
      boot_done    <= 1'b0;
      tamper_force <= 1'b0;
    end else begin
      st <= st_nx;
      if (boot_fire) begin
        boot_done <= 1'b1;
        if (!tamper_sw_en) tamper_force <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int unsigned   AW        = 4,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] KEY_ADDR  = 4'hF,
  parameter logic [AW-1:0] LOCK_ADDR = 4'hE,
  parameter logic [DW-1:0] KEY_B     = 8'hAA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_en_gate,
  input logic          locked,
  input logic          tamper_force
);
  // R6
  no_blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !wr_en_gate);

  // R11
  key_never_passed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == KEY_ADDR) |-> !wr_en_gate);

  // R3
  lock_cmd_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_stb && wr_addr == LOCK_ADDR && wr_data[0]) |=> locked);

  // R7
  unlock_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_stb && wr_addr == KEY_ADDR && wr_data == KEY_B));

  // R8
  stays_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(wr_stb && wr_addr == KEY_ADDR)) |=> locked);

  // R5
  tamper_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_force |=> tamper_force);
endmodule

bind wp_guard wp_guard_chk #(
  .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .LOCK_ADDR(LOCK_ADDR), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_en_gate(wr_en_gate), .locked(locked),
  .tamper_force(tamper_force)
);

// File: tb/test_wp_guard.sv
`timescale 1ns/1ps
module test_wp_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tamper_sw_en = 1'b0;
  logic       wr_en_gate, locked, tamper_force;

  int checks = 0;
  int fails  = 0;

  // reference model state: 0 open after reset, 1 locked, 2 service window
  int mode, boot_ticks, win_ticks;
  bit boot_over, first_key, forced;

  always #10 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .tamper_sw_en(tamper_sw_en),
    .wr_en_gate(wr_en_gate), .locked(locked), .tamper_force(tamper_force)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit g;
    g = wr_stb && (mode != 1) && (wr_addr != 4'hE) && (wr_addr != 4'hF);
    check(req, "locked", int'(locked), (mode == 1) ? 1 : 0);
    check(req, "wr_en_gate", int'(wr_en_gate), int'(g));
    check(req, "tamper_force", int'(tamper_force), int'(forced));
  endtask

  task automatic model_reset();
    mode = 0; boot_ticks = 0; win_ticks = 0;
    boot_over = 0; first_key = 0; forced = 0;
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 0; sec_tick = 0;
    model_reset();
    #1 compare(req);
    @(negedge clk);
    rst_n = 1'b1;
    #1 compare(req);
  endtask

  // one cycle: drive, compare, advance model
  task automatic step(string req, bit stb, logic [3:0] a, logic [7:0] d, bit tk);
    bit lockc, unl, bfire, wfire;
    int nmode;
    @(negedge clk);
    wr_stb = stb; wr_addr = a; wr_data = d; sec_tick = tk;
    #1 compare(req);
    lockc = stb && a == 4'hE && d[0] && mode != 1;
    unl   = mode == 1 && stb && a == 4'hF && d == 8'hAA && first_key;
    bfire = !boot_over && tk && boot_ticks == 14;
    wfire = mode == 2 && tk && win_ticks == 1;
    nmode = mode;
    if (mode == 0 && (lockc || bfire)) nmode = 1;
    if (mode == 2 && (lockc || wfire)) nmode = 1;
    if (unl) nmode = 2;
    if (unl || lockc) win_ticks = 0;
    else if (mode == 2 && tk) win_ticks = wfire ? 0 : win_ticks + 1;
    if (mode != 1) first_key = 0;
    else if (stb) first_key = (a == 4'hF && d == 8'h55);
    if (tk && !boot_over) begin
      if (boot_ticks == 14) begin
        boot_over = 1;
        if (!tamper_sw_en) forced = 1;
      end else boot_ticks++;
    end
    mode = nmode;
  endtask

  task automatic idle(string req, int n, bit tk);
    for (int i = 0; i < n; i++) step(req, 0, 4'h0, 8'h00, tk);
  endtask

  task automatic open_up(string req);
    step(req, 1, 4'hF, 8'h55, 0);
    step(req, 1, 4'hF, 8'hAA, 0);
  endtask

  initial begin
    model_reset();
    do_reset("R1");
    // R2 R11 R3: writes in the post-reset window
    step("R2", 1, 4'h3, 8'h12, 0);
    step("R2", 1, 4'h0, 8'hFF, 0);
    step("R11", 1, 4'hF, 8'h55, 0);
    step("R11", 1, 4'hF, 8'hAA, 0);
    step("R3", 1, 4'hE, 8'h00, 0);
    idle("R3", 1, 0);
    // R4 R5: fifteen ticks with tamper bits clear
    tamper_sw_en = 0;
    for (int i = 0; i < 15; i++) begin
      step("R4", 1, 4'h2, 8'h01, 1);
      idle("R4", 1, 0);
    end
    idle("R5", 2, 0);
    // R6: all writes blocked
    step("R6", 1, 4'h3, 8'h33, 0);
    step("R6", 1, 4'hE, 8'h01, 0);
    // R8: broken sequences
    step("R8", 1, 4'hF, 8'h55, 0);
    step("R8", 1, 4'h3, 8'h00, 0);
    step("R8", 1, 4'hF, 8'hAA, 0);
    step("R8", 1, 4'hF, 8'h55, 0);
    step("R8", 1, 4'hF, 8'h12, 0);
    step("R8", 1, 4'hF, 8'hAA, 0);
    step("R8", 1, 4'hF, 8'hAA, 0);
    // R7: repeated 0x55, idle gap, then 0xAA with a tick in the same cycle
    step("R7", 1, 4'hF, 8'h55, 0);
    step("R7", 1, 4'hF, 8'h55, 0);
    idle("R7", 2, 0);
    step("R9", 1, 4'hF, 8'hAA, 1);
    step("R9", 1, 4'h4, 8'h44, 0);
    idle("R9", 2, 1);
    idle("R9", 3, 0);
    // R10: lock mid window, then a fresh window gets two full ticks
    open_up("R10");
    idle("R10", 1, 1);
    step("R10", 1, 4'hE, 8'h01, 0);
    idle("R10", 1, 0);
    open_up("R10");
    idle("R10", 1, 1);
    step("R10", 1, 4'h5, 8'h55, 0);
    idle("R10", 1, 1);
    idle("R10", 2, 0);
    // second power-on: tamper bits set, early lock, deadline inside a window
    do_reset("R1");
    tamper_sw_en = 1;
    idle("R5", 5, 1);
    step("R3", 1, 4'hE, 8'h01, 0);
    idle("R3", 1, 0);
    idle("R4", 8, 1);
    open_up("R7");
    idle("R5", 1, 1);
    idle("R5", 3, 0);
    open_up("R9");
    idle("R9", 3, 1);
    idle("R5", 2, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule